// File: doc/BRIEF.md
# Biphasic Stimulus and Impedance Sample Sequencer

This block is the timing engine behind one stimulation current driver. Once armed, it steps through one pulse after another. Each pulse has a start delay, a leading drive phase, a quiet gap, a compensating drive phase of opposite polarity, and a grounding interval that shorts the electrode to drain residual charge. The driver enable, the drive direction and the intensity code are registered outputs that follow the active phase. A one-cycle onset flag marks the first driven cycle of every pulse so that downstream sample logic can tag the converter data.

In impedance mode the sequencer also issues three one-cycle capture strobes for an external converter:

- one just after onset;
- one at the end of the leading phase;
- one at the end of the gap.

These give the three electrode voltages needed to fit a simple resistor-capacitor electrode model.

A one-hot select output steers the driver to one of four electrodes. All timing values are in clock ticks. They are latched at the start of each pulse, so software may rewrite them at any time without corrupting a pulse in progress. The repetition period is wide enough to reach 1 Hz at clock rates of a few hundred MHz.

Top module: `biphase_stim_seq`

## Requirements
- R1: A pulse runs its phases in this fixed order: start delay (`t_start` cycles), leading phase (`t_lead`), gap (`t_gap`), compensating phase (`t_comp`), grounding (`t_gnd`). Each phase lasts exactly its programmed number of cycles. The first cycle of a pulse is visible on the outputs one clock after `run` is first sampled high in idle.
- R2: A phase programmed to zero takes no cycles. `t_comp = 0` or `t_lead = 0` therefore gives a monophasic pulse.
- R3: `drv_en` is high only in the leading and compensating phases. `drv_pos` equals `lead_pol` in the leading phase and its inverse in the compensating phase. `drv_amp` carries `amp` while driving and is 0 otherwise.
- R4: `gnd_sw` is high exactly for the grounding cycles and is never high together with `drv_en`.
- R5: `onset` is high for one cycle, namely the first cycle of the pulse in which `drv_en` is high.
- R6: With `imp_mode` high, the strobes fire as follows, and none of them fires with `imp_mode` low:
  - `smp_v0` fires in the cycle after `onset`;
  - `smp_v1` fires in the first cycle after a non-empty leading phase;
  - `smp_v2` fires in the first cycle after a non-empty gap.
- R7: Successive pulses start `t_period` cycles apart, start to start, with 0 treated as 1. If a pulse and its grounding together take longer than that, the next pulse starts right after the grounding ends.
- R8: When `run` goes low, the current pulse completes including grounding. No new pulse starts and all drive outputs stay low.
- R9: All timing, polarity, intensity and mode inputs are captured when a pulse starts. Changes during the pulse affect only later pulses.
- R10: `elec_sel` is one-hot with bit `elec_idx` set. It loads only while the sequencer is idle and keeps its value during a run.
- R11: Synchronous reset clears every output to 0, sets `elec_sel` to 4'b0001, and forces the idle state, even in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep pulsing while high |
| t_start | input | TW | Start delay in cycles |
| t_lead | input | TW | Leading phase width |
| t_gap | input | TW | Gap (interpulse delay) width |
| t_comp | input | TW | Compensating phase width |
| t_gnd | input | TW | Grounding interval width |
| t_period | input | PW | Start-to-start repetition period |
| imp_mode | input | 1 | Enable the three capture strobes |
| lead_pol | input | 1 | Direction of the leading phase |
| amp | input | AW | Intensity code |
| elec_idx | input | SW | Electrode index for the select |
| drv_en | output | 1 | Current driver enable |
| drv_pos | output | 1 | Drive direction |
| drv_amp | output | AW | Intensity to the driver |
| gnd_sw | output | 1 | Electrode grounding switch |
| onset | output | 1 | First driven cycle of a pulse |
| smp_v0 | output | 1 | Capture strobe after onset |
| smp_v1 | output | 1 | Capture strobe after the leading phase |
| smp_v2 | output | 1 | Capture strobe after the gap |
| elec_sel | output | NE | One-hot electrode select |

## Verification
The hardest situation to reach from the ports is `run` falling on exactly the cycle that would otherwise launch the next pulse, combined with a second case: configuration inputs rewritten in the middle of a pulse. The bench drops `run` right after sampling the last cycle of the second period, and checks that the relaunch is suppressed. In a separate directed run it rewrites the intensity, polarity, leading width and mode one cycle after launch, then drops `run` mid-pulse. The expected waveform comes from a closed-form phase model evaluated at each cycle offset, so zero-length phases and stretched periods are predicted independently of the state machine.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_LEAD  = 3'd2,
    PH_GAP   = 3'd3,
    PH_COMP  = 3'd4,
    PH_GND   = 3'd5,
    PH_REST  = 3'd6
  } phase_t;
  localparam int NPH = 5; // phases with a programmable length
endpackage

// File: rtl/sq_phase_ctrl.sv
module sq_phase_ctrl
  import stim_seq_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = 28,
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic [NPH*TW-1:0] lens_i,
  input  logic [PW-1:0]     per_i,
  input  logic              imp_i,
  input  logic              pol_i,
  input  logic [AW-1:0]     amp_i,
  output phase_t            st_q,
  output phase_t            st_d,
  output logic              launch,
  output logic              last,
  output logic              imp_q,
  output logic              pol_u,
  output logic [AW-1:0]     amp_u
);
  localparam int LW = NPH * TW;

  logic [LW-1:0] lens_q, lens_u;
  logic [PW-1:0] per_q, pc_q, per_m1;
  logic [TW-1:0] cnt_q, len_d;
  logic          pol_q, per_done, enter;
  logic [AW-1:0] amp_q;
  logic [2:0]    nxt_idx;

  function automatic logic [TW-1:0] plen(phase_t p, logic [LW-1:0] l);
    case (p)
      PH_START: plen = l[0*TW +: TW];
      PH_LEAD:  plen = l[1*TW +: TW];
      PH_GAP:   plen = l[2*TW +: TW];
      PH_COMP:  plen = l[3*TW +: TW];
      PH_GND:   plen = l[4*TW +: TW];
      default:  plen = '0;
    endcase
  endfunction

  // first phase at or after index 'from' with a non-zero length
  function automatic phase_t seek(logic [2:0] from, logic [LW-1:0] l);
    seek = PH_REST;
    for (int i = NPH; i >= 1; i--) begin
      if (i >= int'(from) && l[(i-1)*TW +: TW] != '0) seek = phase_t'(3'(i));
    end
  endfunction

  assign per_m1   = (per_q == '0) ? '0 : per_q - 1'b1;
  assign per_done = (pc_q >= per_m1);
  assign last     = (cnt_q == '0);
  assign nxt_idx  = st_q + 3'd1;

  always_comb begin
    st_d   = st_q;
    launch = 1'b0;
    case (st_q)
      PH_IDLE: if (run_i) launch = 1'b1;
      PH_REST: begin
        if (!run_i)        st_d   = PH_IDLE;
        else if (per_done) launch = 1'b1;
      end
      default: begin
        if (last) begin
          st_d = seek(nxt_idx, lens_q);
          if (st_d == PH_REST) begin
            if (!run_i)        st_d   = PH_IDLE;
            else if (per_done) launch = 1'b1;
          end
        end
      end
    endcase
    if (launch) st_d = seek(3'd1, lens_i);
  end

  assign lens_u = launch ? lens_i : lens_q;
  assign pol_u  = launch ? pol_i  : pol_q;
  assign amp_u  = launch ? amp_i  : amp_q;
  assign enter  = launch || (st_d != st_q);
  assign len_d  = plen(st_d, lens_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      pc_q   <= '0;
      lens_q <= '0;
      per_q  <= '0;
      imp_q  <= 1'b0;
      pol_q  <= 1'b0;
      amp_q  <= '0;
    end else begin
      st_q <= st_d;
      if (launch) begin
        lens_q <= lens_i;
        per_q  <= per_i;
        imp_q  <= imp_i;
        pol_q  <= pol_i;
        amp_q  <= amp_i;
      end
      if (enter)            cnt_q <= (len_d == '0) ? '0 : len_d - 1'b1;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (launch)           pc_q  <= '0;
      else if (pc_q != '1)  pc_q  <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/sq_drive_out.sv
module sq_drive_out
  import stim_seq_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_t        st_q,
  input  phase_t        st_d,
  input  logic          launch,
  input  logic          last,
  input  logic          imp_q,
  input  logic          pol_u,
  input  logic [AW-1:0] amp_u,
  output logic          drv_en,
  output logic          drv_pos,
  output logic [AW-1:0] drv_amp,
  output logic          gnd_sw,
  output logic          onset,
  output logic          smp_v0,
  output logic          smp_v1,
  output logic          smp_v2
);
  logic drive_d, fired_q;

  assign drive_d = (st_d == PH_LEAD) || (st_d == PH_COMP);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en  <= 1'b0;
      drv_pos <= 1'b0;
      drv_amp <= '0;
      gnd_sw  <= 1'b0;
      onset   <= 1'b0;
      fired_q <= 1'b0;
      smp_v0  <= 1'b0;
      smp_v1  <= 1'b0;
      smp_v2  <= 1'b0;
    end else begin
      drv_en  <= drive_d;
      drv_pos <= (st_d == PH_LEAD) ? pol_u : ((st_d == PH_COMP) ? ~pol_u : 1'b0);
      drv_amp <= drive_d ? amp_u : '0;
      gnd_sw  <= (st_d == PH_GND);
      onset   <= drive_d && (launch || !fired_q);
      fired_q <= launch ? drive_d : (fired_q || drive_d);
      smp_v0  <= onset && imp_q;
      smp_v1  <= imp_q && (st_q == PH_LEAD) && last;
      smp_v2  <= imp_q && (st_q == PH_GAP) && last;
    end
  end
endmodule

// File: rtl/sq_elec_steer.sv
module sq_elec_steer #(
  parameter int NE = 4,
  localparam int SW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic [SW-1:0] idx,
  output logic [NE-1:0] sel
);
  localparam logic [NE-1:0] ONE = {{(NE-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       sel <= ONE;
    else if (idle) sel <= ONE << idx;
  end
endmodule

// File: rtl/biphase_stim_seq.sv
module biphase_stim_seq
  import stim_seq_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = 28,
  parameter int AW = 8,
  parameter int NE = 4,
  localparam int SW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] t_start,
  input  logic [TW-1:0] t_lead,
  input  logic [TW-1:0] t_gap,
  input  logic [TW-1:0] t_comp,
  input  logic [TW-1:0] t_gnd,
  input  logic [PW-1:0] t_period,
  input  logic          imp_mode,
  input  logic          lead_pol,
  input  logic [AW-1:0] amp,
  input  logic [SW-1:0] elec_idx,
  output logic          drv_en,
  output logic          drv_pos,
  output logic [AW-1:0] drv_amp,
  output logic          gnd_sw,
  output logic          onset,
  output logic          smp_v0,
  output logic          smp_v1,
  output logic          smp_v2,
  output logic [NE-1:0] elec_sel
);
  phase_t        st_cur, st_nxt;
  logic          launch, last, imp_q, pol_u;
  logic [AW-1:0] amp_u;

  sq_phase_ctrl #(.TW(TW), .PW(PW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .run_i(run),
    .lens_i({t_gnd, t_comp, t_gap, t_lead, t_start}),
    .per_i(t_period), .imp_i(imp_mode), .pol_i(lead_pol), .amp_i(amp),
    .st_q(st_cur), .st_d(st_nxt), .launch(launch), .last(last),
    .imp_q(imp_q), .pol_u(pol_u), .amp_u(amp_u)
  );

  sq_drive_out #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .st_q(st_cur), .st_d(st_nxt), .launch(launch),
    .last(last), .imp_q(imp_q), .pol_u(pol_u), .amp_u(amp_u),
    .drv_en(drv_en), .drv_pos(drv_pos), .drv_amp(drv_amp), .gnd_sw(gnd_sw),
    .onset(onset), .smp_v0(smp_v0), .smp_v1(smp_v1), .smp_v2(smp_v2)
  );

  sq_elec_steer #(.NE(NE)) u_sel (
    .clk(clk), .rst(rst), .idle(st_cur == PH_IDLE), .idx(elec_idx), .sel(elec_sel)
  );
endmodule

// File: rtl/biphase_stim_chk.sv
module biphase_stim_chk
  import stim_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int NE = 4
) (
  input logic          clk,
  input logic          rst,
  input phase_t        st,
  input logic          drv_en,
  input logic [AW-1:0] drv_amp,
  input logic          gnd_sw,
  input logic          onset,
  input logic          smp_v0,
  input logic          smp_v1,
  input logic          smp_v2,
  input logic [NE-1:0] sel
);
  p_drive_phase_r1: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> (st == PH_LEAD || st == PH_COMP));
  p_amp_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> (drv_amp == '0));
  p_gnd_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(drv_en && gnd_sw));
  p_onset_drive_r5: assert property (@(posedge clk) disable iff (rst)
    onset |-> drv_en);
  p_v0_follow_r6: assert property (@(posedge clk) disable iff (rst)
    smp_v0 |-> $past(onset));
  p_v1_lead_r6: assert property (@(posedge clk) disable iff (rst)
    smp_v1 |-> $past(st == PH_LEAD));
  p_v2_gap_r6: assert property (@(posedge clk) disable iff (rst)
    smp_v2 |-> $past(st == PH_GAP));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE) |-> (!drv_en && !gnd_sw));
  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == 1);
  p_sel_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st != PH_IDLE) |=> $stable(sel));
endmodule

bind biphase_stim_seq biphase_stim_chk #(.AW(AW), .NE(NE)) u_chk (
  .clk(clk), .rst(rst), .st(st_cur), .drv_en(drv_en), .drv_amp(drv_amp),
  .gnd_sw(gnd_sw), .onset(onset), .smp_v0(smp_v0), .smp_v1(smp_v1),
  .smp_v2(smp_v2), .sel(elec_sel)
);

// File: tb/sim_biphase_stim_seq.sv
`timescale 1ns/1ps
module sim_biphase_stim_seq;
  localparam int TW = 16;
  localparam int PW = 28;
  localparam int AW = 8;
  localparam int NE = 4;

  // start, lead, gap, comp, gnd, period, imp, pol, amp
  localparam int NV = 6;
  localparam int VEC [NV][9] = '{
    '{2, 3, 2, 3, 2, 16, 1, 1, 85},  // R1 R6 full biphasic
    '{0, 1, 0, 1, 1,  5, 1, 0, 163}, // R2 R6 zero start and gap
    '{1, 4, 3, 0, 2, 12, 1, 1, 60},  // R2 monophasic, comp zero
    '{1, 0, 0, 3, 1,  8, 1, 0, 201}, // R2 R5 lead zero, onset in comp
    '{3, 2, 1, 2, 4,  6, 0, 1, 17},  // R7 stretched period, R6 no strobes
    '{0, 2, 2, 2, 0,  0, 1, 1, 240}  // R7 period zero, R2 no grounding
  };
  localparam string CTX [NV] = '{"R1 R6", "R2 R6", "R2", "R2 R5", "R7 R6", "R7 R2"};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic [TW-1:0] t_start = '0, t_lead = '0, t_gap = '0, t_comp = '0, t_gnd = '0;
  logic [PW-1:0] t_period = '0;
  logic          imp_mode = 1'b0, lead_pol = 1'b0;
  logic [AW-1:0] amp = '0;
  logic [1:0]    elec_idx = '0;
  logic          drv_en, drv_pos, gnd_sw, onset, smp_v0, smp_v1, smp_v2;
  logic [AW-1:0] drv_amp;
  logic [NE-1:0] elec_sel;

  int nchk = 0, nbad = 0;
  bit finished = 1'b0;
  int cs, cl, cg, cc, cd, cT, ci, cp, ca;

  always #4 clk = ~clk;

  biphase_stim_seq #(.TW(TW), .PW(PW), .AW(AW), .NE(NE)) u0 (
    .clk(clk), .rst(rst), .run(run), .t_start(t_start), .t_lead(t_lead),
    .t_gap(t_gap), .t_comp(t_comp), .t_gnd(t_gnd), .t_period(t_period),
    .imp_mode(imp_mode), .lead_pol(lead_pol), .amp(amp), .elec_idx(elec_idx),
    .drv_en(drv_en), .drv_pos(drv_pos), .drv_amp(drv_amp), .gnd_sw(gnd_sw),
    .onset(onset), .smp_v0(smp_v0), .smp_v1(smp_v1), .smp_v2(smp_v2),
    .elec_sel(elec_sel)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int period_of();
    int p;
    int tot;
    tot = cs + cl + cg + cc + cd;
    p = (cT < 1) ? 1 : cT;
    if (tot > p) p = tot;
    return p;
  endfunction

  // closed-form expectation {en,pos,amp,gnd,onset,v0,v1,v2} at offset k
  function automatic logic [14:0] model(int k);
    int kk, k0, b1, b2, b3, b4, b5;
    logic en, pos, gnd, on, v0, v1, v2;
    kk = k % period_of();
    b1 = cs; b2 = b1 + cl; b3 = b2 + cg; b4 = b3 + cc; b5 = b4 + cd;
    k0 = (cl > 0) ? b1 : ((cc > 0) ? b3 : -10);
    en  = (kk >= b1 && kk < b2) || (kk >= b3 && kk < b4);
    pos = (kk >= b1 && kk < b2) ? cp[0] : ((kk >= b3 && kk < b4) ? ~cp[0] : 1'b0);
    gnd = (kk >= b4 && kk < b5);
    on  = (kk == k0);
    v0  = (ci != 0) && (kk == k0 + 1);
    v1  = (ci != 0) && (cl > 0) && (kk == b2);
    v2  = (ci != 0) && (cg > 0) && (kk == b3);
    return {en, pos, en ? 8'(ca) : 8'd0, gnd, on, v0, v1, v2};
  endfunction

  task automatic load_cfg(int v);
    cs = VEC[v][0]; cl = VEC[v][1]; cg = VEC[v][2]; cc = VEC[v][3]; cd = VEC[v][4];
    cT = VEC[v][5]; ci = VEC[v][6]; cp = VEC[v][7]; ca = VEC[v][8];
  endtask

  task automatic apply_cfg();
    t_start = TW'(cs); t_lead = TW'(cl); t_gap = TW'(cg); t_comp = TW'(cc);
    t_gnd = TW'(cd); t_period = PW'(cT); imp_mode = ci[0]; lead_pol = cp[0];
    amp = AW'(ca);
  endtask

  // launch pulses, compare each cycle, drop run after sampling drop_k
  task automatic exercise(int drop_k, bit mutate, bit selmut, string ctx);
    int p, tot, endk;
    logic [14:0] got, exp;
    string tag;
    p = period_of();
    tot = cs + cl + cg + cc + cd;
    endk = ((drop_k % p) < tot) ? (drop_k / p) * p + tot : drop_k + 1;
    apply_cfg();
    run = 1'b1;
    tick();
    for (int k = 0; k <= endk + 5; k++) begin
      got = {drv_en, drv_pos, drv_amp, gnd_sw, onset, smp_v0, smp_v1, smp_v2};
      exp = (k >= endk) ? 15'd0 : model(k);
      if (got[14:5] !== exp[14:5])  tag = "R3";
      else if (got[4] !== exp[4])   tag = "R4";
      else if (got[3] !== exp[3])   tag = "R5";
      else                          tag = "R6";
      if (k >= endk) tag = "R8";
      chk(got === exp, $sformatf("%s [%s] k=%0d", tag, ctx, k), 32'(got), 32'(exp));
      if (selmut && k == 2)
        chk(elec_sel === 4'b0100, "R10 select held during run", 32'(elec_sel), 32'h4);
      if (k == 0 && mutate) begin
        // R9: rewrite inputs mid-pulse; the running pulse must ignore them
        amp = 8'h0F; lead_pol = ~lead_pol; t_lead = 16'd7; imp_mode = 1'b0;
      end
      if (k == 0 && selmut) elec_idx = 2'd3;
      if (k == drop_k) run = 1'b0;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL R1 watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk({drv_en, drv_pos, drv_amp, gnd_sw, onset, smp_v0, smp_v1, smp_v2} === 15'd0,
        "R11 outputs in reset", 32'(drv_amp), 32'h0);
    chk(elec_sel === 4'b0001, "R11 select in reset", 32'(elec_sel), 32'h1);
    rst = 1'b0;
    elec_idx = 2'd2;
    tick();
    tick();
    chk(elec_sel === 4'b0100, "R10 select loads in idle", 32'(elec_sel), 32'h4);

    // table walk: two periods each, run dropped on the would-be relaunch edge (R8)
    for (int v = 0; v < NV; v++) begin
      load_cfg(v);
      exercise(2 * period_of() - 1, 1'b0, 1'b0, CTX[v]);
    end

    // R9 and R8: mid-pulse rewrite of inputs, run dropped inside the first pulse
    load_cfg(0);
    exercise(3, 1'b1, 1'b0, "R9 R8");

    // R10: index changed during a run is held off until idle
    load_cfg(1);
    exercise(2 * period_of() - 1, 1'b0, 1'b1, "R10");
    tick();
    chk(elec_sel === 4'b1000, "R10 select loads after run", 32'(elec_sel), 32'h8);

    // R11: reset in the middle of the leading phase
    load_cfg(0);
    apply_cfg();
    run = 1'b1;
    repeat (4) tick();
    chk(drv_en === 1'b1, "R1 driving before reset", 32'(drv_en), 32'h1);
    rst = 1'b1;
    tick();
    chk({drv_en, drv_amp, gnd_sw, onset} === 11'd0, "R11 mid-pulse reset clears",
        32'(drv_amp), 32'h0);
    chk(elec_sel === 4'b0001, "R11 mid-pulse reset select", 32'(elec_sel), 32'h1);
    run = 1'b0;
    rst = 1'b0;
    tick();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule